// File: doc/BRIEF.md
# FIFO Read Pointer with Bookmark Rewind

This block runs the read-side pointer logic of a FIFO. On each read clock it moves the read address and reports how many words can still be read. It also keeps a write address, which the same resets clear and which advances on write strobes, so that the readable count and the full indication can be formed locally. The memory array, moving pointers between clock domains and bus-width conversion are handled elsewhere.

A consumer can bookmark the word it is reading by raising `markIn`. While `markIn` stays high, the bookmark is held. Pulling `rtN` low then rewinds the read address to the bookmark, so a block of data can be sent again. While a bookmark is held, the write side treats the bookmark as the oldest live word, so the data to be resent cannot be overwritten.

The master reset clears both pointers and latches the timing mode, standard or first-word-fall-through, from `fwftSel`. The partial reset clears the pointers and leaves the latched mode as it was.

Top module: `rdptr_mark_top`

## Requirements
- R1: While `mrstN` is low at a clock edge, both addresses become 0, `wordCount` becomes 0, `empty` is 1, `full` is 0, and `fwftMode` takes the value of `fwftSel`. This reset has priority over every other input.
- R2: While `prstN` is low (and `mrstN` is high) at a clock edge, both addresses and `wordCount` become 0 and any held bookmark is dropped. `fwftMode` keeps its value.
- R3: A high `rdEn` while `empty` is 0 moves `rdAddr` up by one (modulo the depth) at the next edge. A high `rdEn` while `empty` is 1 leaves `rdAddr` unchanged.
- R4: A high `wrEn` while `full` is 0 moves `wrAddr` up by one (modulo the depth) at the next edge. While `full` is 1, writes are ignored.
- R5: `wordCount` equals the number of written words not yet read, with a range of 0 to 2^ADDR_W. `empty` is 1 exactly when `wordCount` is 0.
- R6: `markIn` sampled high at an edge with no bookmark held stores the `rdAddr` of that edge as the bookmark. The bookmark stays fixed while `markIn` remains high. Sampling `markIn` low releases it.
- R7: `rtN` sampled low with a bookmark held loads `rdAddr` with the bookmark at that edge, and `wordCount` becomes the written words counted from the bookmark. A `rdEn` in the same cycle is ignored.
- R8: `rtN` sampled low with no bookmark held has no effect, and `rdEn` acts as in R3.
- R9: While a bookmark is held, `full` is 1 when 2^ADDR_W words have been written since the bookmarked word, whatever the read position. After the bookmark is released, `full` uses the read pointer again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; every register updates on its rising edge |
| mrstN | input | 1 | Master reset, active low, synchronous |
| prstN | input | 1 | Partial reset, active low, synchronous |
| fwftSel | input | 1 | Timing mode sampled during master reset (1 = first-word-fall-through) |
| wrEn | input | 1 | Write strobe, advances the write address |
| rdEn | input | 1 | Read strobe, advances the read address |
| markIn | input | 1 | Bookmark request, held high to keep the bookmark |
| rtN | input | 1 | Rewind to bookmark, active low |
| rdAddr | output | ADDR_W | Current read location |
| wrAddr | output | ADDR_W | Current write location |
| wordCount | output | ADDR_W+1 | Words available to read |
| empty | output | 1 | No word available |
| full | output | 1 | No free location, bounded by the bookmark when held |
| fwftMode | output | 1 | Latched timing mode |

## Verification
The assertions expect every input to be stable and known at each rising clock edge. They also expect the master reset to be held for at least one edge before any check applies, so that the latched mode and the pointers start from known values. The bookmark-rewind property relies on a shadow of the held flag and of the bookmarked address, rebuilt from `markIn` and `rdAddr` alone. For that reason the bench changes inputs only one time unit after an edge and keeps them constant through the following edge, and it first pulses the master reset for two edges.

// File: rtl/rdptr_pkg.sv
package rdptr_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic clrAll;    // clear pointers and bookmark
    logic loadMode;  // latch timing mode
    logic rewind;    // read pointer <- bookmark
    logic advRd;     // read pointer + 1
    logic advWr;     // write pointer + 1
    logic holdMark;  // bookmark valid next cycle
    logic capMark;   // store read pointer as bookmark
  } ptrStrobe_t;

endpackage

// File: rtl/rdptr_ctrl.sv
module rdptr_ctrl
  import rdptr_pkg::*;
(
  input  logic       mrstN,
  input  logic       prstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       markIn,
  input  logic       rtN,
  input  logic       empty,
  input  logic       full,
  input  logic       markValid,
  output ptrStrobe_t stb
);

  always_comb begin
    stb          = '0;
    stb.loadMode = !mrstN;
    stb.clrAll   = !mrstN || !prstN;
    if (!stb.clrAll) begin
      // rewind only with a held bookmark; it overrides a same-cycle read
      stb.rewind   = !rtN && markValid;
      stb.advRd    = rdEn && !empty && !stb.rewind;
      stb.advWr    = wrEn && !full;
      stb.holdMark = markIn;
      stb.capMark  = markIn && !markValid;
    end
  end

endmodule

// File: rtl/rdptr_dpath.sv
module rdptr_dpath
  import rdptr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  ptrStrobe_t        stb,
  input  logic              fwftSel,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W:0]   wordCount,
  output logic              empty,
  output logic              full,
  output logic              markValid,
  output logic              fwftMode
);

  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH = {1'b1, {ADDR_W{1'b0}}};

  logic [PW-1:0] rdPtr, wrPtr, markPtr, oldest;

  always_ff @(posedge clk) begin
    if (stb.loadMode) fwftMode <= fwftSel;
    if (stb.clrAll) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      markPtr   <= '0;
      markValid <= 1'b0;
    end else begin
      if (stb.rewind)     rdPtr <= markPtr;
      else if (stb.advRd) rdPtr <= rdPtr + 1'b1;
      if (stb.advWr)      wrPtr <= wrPtr + 1'b1;
      if (stb.capMark)    markPtr <= rdPtr;
      markValid <= stb.holdMark;
    end
  end

  always_comb begin
    oldest    = markValid ? markPtr : rdPtr;
    wordCount = wrPtr - rdPtr;
    empty     = (wordCount == '0);
    full      = ((wrPtr - oldest) == DEPTH);
    rdAddr    = rdPtr[ADDR_W-1:0];
    wrAddr    = wrPtr[ADDR_W-1:0];
  end

endmodule

// File: rtl/rdptr_mark_top.sv
module rdptr_mark_top
  import rdptr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              mrstN,
  input  logic              prstN,
  input  logic              fwftSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              markIn,
  input  logic              rtN,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W:0]   wordCount,
  output logic              empty,
  output logic              full,
  output logic              fwftMode
);

  ptrStrobe_t stb;
  logic       markValid;

  rdptr_ctrl u_ctrl (
    .mrstN     (mrstN),
    .prstN     (prstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .markIn    (markIn),
    .rtN       (rtN),
    .empty     (empty),
    .full      (full),
    .markValid (markValid),
    .stb       (stb)
  );

  rdptr_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .stb       (stb),
    .fwftSel   (fwftSel),
    .rdAddr    (rdAddr),
    .wrAddr    (wrAddr),
    .wordCount (wordCount),
    .empty     (empty),
    .full      (full),
    .markValid (markValid),
    .fwftMode  (fwftMode)
  );

endmodule

// File: rtl/rdptr_chk.sv
module rdptr_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              mrstN,
  input logic              prstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              markIn,
  input logic              rtN,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W:0]   wordCount,
  input logic              empty,
  input logic              full,
  input logic              fwftMode
);

  localparam logic [ADDR_W:0] DEPTH = {1'b1, {ADDR_W{1'b0}}};

  // bookmark shadow rebuilt from port activity only
  logic              heldQ;
  logic [ADDR_W-1:0] markQ;

  always_ff @(posedge clk) begin
    if (!mrstN || !prstN) begin
      heldQ <= 1'b0;
      markQ <= '0;
    end else begin
      heldQ <= markIn;
      if (markIn && !heldQ) markQ <= rdAddr;
    end
  end

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!mrstN)
    $past(mrstN) |-> $stable(fwftMode));

  p_prst_clear_r2: assert property (@(posedge clk) disable iff (!mrstN)
    !prstN |=> (rdAddr == '0 && wrAddr == '0 && wordCount == '0));

  p_rd_step_r3: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && rtN && rdEn && !empty) |=> rdAddr == $past(rdAddr) + 1'b1);

  p_rd_empty_r3: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && rtN && empty) |=> $stable(rdAddr));

  p_wr_step_r4: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && wrEn && !full) |=> wrAddr == $past(wrAddr) + 1'b1);

  p_full_hold_r4: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && full) |=> $stable(wrAddr));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!mrstN)
    wordCount <= DEPTH);

  p_rewind_r7: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && !rtN && heldQ) |=> rdAddr == $past(markQ));

  p_no_mark_rt_r8: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && !rtN && !heldQ && rdEn && !empty) |=> rdAddr == $past(rdAddr) + 1'b1);

endmodule

bind rdptr_mark_top rdptr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .mrstN     (mrstN),
  .prstN     (prstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .markIn    (markIn),
  .rtN       (rtN),
  .rdAddr    (rdAddr),
  .wrAddr    (wrAddr),
  .wordCount (wordCount),
  .empty     (empty),
  .full      (full),
  .fwftMode  (fwftMode)
);

// File: tb/tb_rdptr_mark_top.sv
`timescale 1ns/1ps
module tb_rdptr_mark_top;

  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              mrstN = 1'b0, prstN = 1'b1, fwftSel = 1'b1;
  logic              wrEn = 1'b0, rdEn = 1'b0, markIn = 1'b0, rtN = 1'b1;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [ADDR_W:0]   wordCount;
  logic              empty, full, fwftMode;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rdptr_mark_top #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .fwftSel(fwftSel),
    .wrEn(wrEn), .rdEn(rdEn), .markIn(markIn), .rtN(rtN),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wordCount(wordCount),
    .empty(empty), .full(full), .fwftMode(fwftMode)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doWrites(int n);
    wrEn = 1'b1;
    repeat (n) tick();
    wrEn = 1'b0;
  endtask

  task automatic doReads(int n);
    rdEn = 1'b1;
    repeat (n) tick();
    rdEn = 1'b0;
  endtask

  task automatic pulsePartial();
    prstN = 1'b0;
    tick();
    prstN = 1'b1;
  endtask

  task automatic t_master_reset(logic sel);
    fwftSel = sel;
    mrstN   = 1'b0;
    tick();
    tick();
    mrstN = 1'b1;
    check("R1 rdAddr", rdAddr, 0);
    check("R1 wrAddr", wrAddr, 0);
    check("R1 wordCount", wordCount, 0);
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 fwftMode", fwftMode, sel);
  endtask

  task automatic t_write_read();
    doWrites(5);
    check("R4 wrAddr", wrAddr, 5);
    check("R5 wordCount after writes", wordCount, 5);
    doReads(2);
    check("R3 rdAddr", rdAddr, 2);
    check("R5 wordCount after reads", wordCount, 3);
    doReads(3);
    check("R5 empty", empty, 1);
    doReads(1);
    check("R3 read while empty", rdAddr, 5);
  endtask

  task automatic t_fill();
    doWrites(16);
    check("R4 full", full, 1);
    check("R4 wrAddr wraps", wrAddr, 0);
    check("R5 wordCount full", wordCount, 16);
    doWrites(1);
    check("R4 write while full", wrAddr, 0);
    check("R4 count while full", wordCount, 16);
  endtask

  task automatic t_mark_rewind();
    pulsePartial();
    doWrites(8);
    doReads(2);
    markIn = 1'b1;
    rdEn   = 1'b1;
    tick();             // bookmark = 2, read -> 3
    tick();
    tick();             // read -> 5
    check("R3 reads under mark", rdAddr, 5);
    rtN = 1'b0;         // rdEn still high: ignored
    tick();
    rtN  = 1'b1;
    rdEn = 1'b0;
    check("R7 rewind rdAddr", rdAddr, 2);
    check("R7 rewind wordCount", wordCount, 6);
    doReads(1);
    rtN = 1'b0;
    tick();
    rtN = 1'b1;
    check("R6 bookmark held", rdAddr, 2);
    markIn = 1'b0;
    tick();             // bookmark released
    rtN  = 1'b0;
    rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
    check("R8 rewind without mark reads", rdAddr, 3);
    tick();
    rtN = 1'b1;
    check("R8 rewind without mark idle", rdAddr, 3);
  endtask

  task automatic t_full_mark();
    pulsePartial();
    doWrites(4);
    doReads(2);
    markIn = 1'b1;
    tick();             // bookmark = 2
    doReads(2);         // rdAddr 4
    doWrites(14);       // write pointer 18
    check("R9 full at bookmark", full, 1);
    check("R9 wordCount", wordCount, 14);
    check("R9 wrAddr", wrAddr, 2);
    doWrites(1);
    check("R9 write blocked", wrAddr, 2);
    markIn = 1'b0;
    tick();
    check("R9 full after release", full, 0);
  endtask

  task automatic t_partial();
    markIn = 1'b1;
    tick();             // bookmark at current read location
    markIn  = 1'b0;
    fwftSel = 1'b0;
    pulsePartial();
    check("R2 rdAddr", rdAddr, 0);
    check("R2 wrAddr", wrAddr, 0);
    check("R2 wordCount", wordCount, 0);
    check("R2 mode kept", fwftMode, 1);
    doWrites(3);
    doReads(2);
    rtN = 1'b0;
    tick();
    rtN = 1'b1;
    check("R2 bookmark dropped", rdAddr, 2);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    t_master_reset(1'b1);
    t_write_read();
    t_master_reset(1'b1);
    t_fill();
    t_mark_rewind();
    t_full_mark();
    t_partial();
    t_master_reset(1'b0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule